// File: doc/BRIEF.md
# Serial Packet CRC and Pad Stripper

This block sits on the receive side of a serial link, after symbol decoding. Packets arrive one byte per handshake, with start and end markers. Each packet carries a 16-bit CRC at its end. It may carry two alignment fill bytes after that CRC. A packet whose content is longer than 80 bytes also carries a second CRC, placed right after its 80th content byte. The block removes all of these bytes, so the downstream logic sees only header and payload. It moves the end marker onto the last byte that is really content.

A trailer is either two or four bytes long. The block can only tell which bytes form the trailer once the end marker arrives. So it keeps a small window: a content byte is released only when four more bytes of the same packet have been taken in. The sender marks a padded packet by raising a pad flag together with the end marker. It does so when the packet length up to and including the final CRC is not a multiple of four. An optional checker recomputes both CRCs and flags a mismatch together with the final output byte.

Top module: `crc_pad_stripper`

## Requirements
- R1: During and straight after reset, `out_valid` is low and `in_ready` is high.
- R2: The last two received bytes of an unpadded packet (`in_pad` low with `in_eop`) are the final CRC and never appear at the output. `out_eop` is raised on the byte that came just before them.
- R3: When `in_pad` is high with `in_eop`, the last four received bytes are dropped: two fill bytes, and before them the final CRC. `out_eop` is raised on the byte before that CRC.
- R4: When a packet has more than 80 content bytes, received bytes at positions 80 and 81 (counting from 0 at `in_sop`) are dropped. All other content bytes keep their order.
- R5: When a packet has 80 or fewer content bytes, every content byte is forwarded, including one at position 79. Only the trailer is removed.
- R6: `out_sop` is high on exactly the first output byte of each packet. Every output packet ends with `out_eop` before the next one starts.
- R7: While `out_valid` is high and `out_ready` is low, the output byte and its flags hold steady. Across any pattern of stalls, no byte is lost, repeated or reordered.
- R8: The final CRC is sent high byte first. It is compared with CRC-16: polynomial 0x1021, initial value 0xFFFF, input fed MSB first, no reflection, no final XOR. The CRC runs over every received byte before the final CRC, including the early CRC bytes. On a mismatch, `out_crc_err` is high on the `out_eop` byte.
- R9: The early CRC (positions 80 and 81, high byte first) is compared with the same CRC taken over positions 0 to 79. On a mismatch, `out_crc_err` is high on that packet's `out_eop` byte.
- R10: `out_crc_err` is low on every output byte that does not carry `out_eop`, and on the `out_eop` byte of a packet whose CRCs both match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Received byte |
| in_sop | input | 1 | First byte of a received packet |
| in_eop | input | 1 | Last byte of a received packet |
| in_pad | input | 1 | Qualified by in_eop: the packet ends with two fill bytes |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Content byte |
| out_sop | output | 1 | First content byte of a packet |
| out_eop | output | 1 | Last content byte of a packet |
| out_crc_err | output | 1 | CRC mismatch, valid with out_eop |

## Verification
Two events can land on the same clock edge. One is dropping an early CRC byte from the head of the window, which needs no output slot. The other is the output register stalling because `out_ready` is low. A new byte may also enter the window in that same cycle. The bench provokes this by sending packets well over 80 bytes while randomly gapping the input and stalling the output. It judges the result by comparing the output, byte by byte, against a model built from the requirements, and by checking that a stalled output byte does not change.

// File: rtl/crc_strip_pkg.sv
package crc_strip_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       early;     // byte belongs to the mid-packet CRC
    logic       early_hi;  // first (high) byte of that CRC
  } win_slot_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  byte_in,
                                             input logic [15:0] poly);
    logic [15:0] r;
    r = crc_in ^ {byte_in, 8'h00};
    for (int b = 0; b < 8; b++) begin
      r = r[15] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_strip_window.sv
module crc_strip_window
  import crc_strip_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  win_slot_t               push_slot,
  input  logic                    pop,
  input  logic                    flush,
  output win_slot_t [DEPTH-1:0]   slots,
  output logic [CNT_W-1:0]        count
);

  logic [CNT_W-1:0] wr_idx;
  assign wr_idx = count - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (rst || flush) count <= '0;
    else              count <= count + CNT_W'(push) - CNT_W'(pop);
  end

  // Shift register with indexed write: slot 0 is always the oldest byte.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (push && wr_idx == CNT_W'(g)) slots[g] <= push_slot;
        else if (pop)                    slots[g] <= slots[g+1];
      end
    end else begin : g_end
      always_ff @(posedge clk) begin
        if (push && wr_idx == CNT_W'(g)) slots[g] <= push_slot;
      end
    end
  end

endmodule

// File: rtl/crc_strip_check.sv
module crc_strip_check
  import crc_strip_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pop,
  input  logic       last,
  input  win_slot_t  head,
  input  logic [7:0] trail_hi,
  input  logic [7:0] trail_lo,
  output logic       bad
);

  logic [15:0] crc_q, crc_nx, early_ref;
  logic [7:0]  early_hi_byte;
  logic        early_bad;

  assign crc_nx = crc16_byte(crc_q, head.data, POLY);
  assign bad    = early_bad || (crc_nx != {trail_hi, trail_lo});

  always_ff @(posedge clk) begin
    if (rst || (pop && last)) begin
      crc_q     <= SEED;
      early_bad <= 1'b0;
    end else if (pop) begin
      crc_q <= crc_nx;
      if (head.early && head.early_hi) begin
        early_ref     <= crc_q;
        early_hi_byte <= head.data;
      end
      if (head.early && !head.early_hi)
        early_bad <= early_bad || ({early_hi_byte, head.data} != early_ref);
    end
  end

endmodule

// File: rtl/crc_pad_stripper.sv
module crc_pad_stripper
  import crc_strip_pkg::*;
#(
  parameter int          IDX_W    = 12,
  parameter int          EARLY_AT = 80,
  parameter bit          CHECK_EN = 1'b1,
  parameter logic [15:0] POLY     = 16'h1021,
  parameter logic [15:0] SEED     = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       in_pad,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       out_crc_err
);

  localparam int CRC_B     = 2;
  localparam int TRAIL_MAX = 2 * CRC_B;
  localparam int DEPTH     = TRAIL_MAX + 1;
  localparam int CNT_W     = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]           idx_q, cur_idx;
  win_slot_t                  new_slot, head;
  win_slot_t [DEPTH-1:0]      slots;
  logic [CNT_W-1:0]           count, cnt_after, trail, keep_q;
  logic                       drain_q, first_q;
  logic                       head_avail, slot_free, pop, emit, last, accept, crc_bad;

  assign cur_idx           = in_sop ? '0 : idx_q;
  assign new_slot.data     = in_data;
  assign new_slot.early    = (cur_idx == IDX_W'(EARLY_AT)) || (cur_idx == IDX_W'(EARLY_AT + 1));
  assign new_slot.early_hi = (cur_idx == IDX_W'(EARLY_AT));

  assign head       = slots[0];
  assign head_avail = drain_q ? (keep_q != '0) : (count == CNT_W'(DEPTH));
  assign slot_free  = !out_valid || out_ready;
  assign pop        = head_avail && (head.early || slot_free);
  assign emit       = pop && !head.early;
  assign last       = pop && drain_q && (keep_q == CNT_W'(1));
  assign in_ready   = !drain_q && ((count < CNT_W'(DEPTH)) || pop);
  assign accept     = in_valid && in_ready;
  assign cnt_after  = count + CNT_W'(1) - CNT_W'(pop);
  assign trail      = in_pad ? CNT_W'(TRAIL_MAX) : CNT_W'(CRC_B);

  crc_strip_window #(.DEPTH(DEPTH)) u_window (
    .clk       (clk),
    .rst       (rst),
    .push      (accept),
    .push_slot (new_slot),
    .pop       (pop),
    .flush     (last),
    .slots     (slots),
    .count     (count)
  );

  if (CHECK_EN) begin : g_check
    crc_strip_check #(.POLY(POLY), .SEED(SEED)) u_check (
      .clk      (clk),
      .rst      (rst),
      .pop      (pop),
      .last     (last),
      .head     (head),
      .trail_hi (slots[1].data),
      .trail_lo (slots[2].data),
      .bad      (crc_bad)
    );
  end else begin : g_nocheck
    assign crc_bad = 1'b0;
  end

  // Packet position and end-of-packet drain control
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      drain_q <= 1'b0;
      keep_q  <= '0;
    end else begin
      if (accept) idx_q <= in_eop ? '0 : cur_idx + IDX_W'(1);
      if (accept && in_eop) begin
        drain_q <= 1'b1;
        keep_q  <= cnt_after - trail;
      end else if (pop && drain_q) begin
        keep_q <= keep_q - CNT_W'(1);
        if (last) drain_q <= 1'b0;
      end
    end
  end

  // Registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_crc_err <= 1'b0;
      first_q     <= 1'b1;
    end else begin
      if (slot_free) begin
        out_valid <= emit;
        if (emit) begin
          out_data    <= head.data;
          out_sop     <= first_q;
          out_eop     <= last;
          out_crc_err <= last && crc_bad;
        end
      end
      if (emit) first_q <= last;
    end
  end

endmodule

// File: rtl/crc_pad_stripper_sva.sv
module crc_pad_stripper_sva (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       out_crc_err
);

  logic open_pkt;
  always_ff @(posedge clk) begin
    if (rst)                         open_pkt <= 1'b0;
    else if (out_valid && out_ready) open_pkt <= !out_eop;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !out_valid);
  a_r1_ready_after_reset: assert property (@(posedge clk) rst |=> in_ready);

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                && $stable(out_eop) && $stable(out_crc_err));

  a_r10_err_only_on_eop: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_crc_err |-> out_eop);

  a_r6_sop_starts_packet: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sop == !open_pkt));

endmodule

bind crc_pad_stripper crc_pad_stripper_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .out_crc_err (out_crc_err)
);

// File: tb/crc_pad_stripper_bench.sv
module crc_pad_stripper_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_pad = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, out_sop, out_eop, out_crc_err;
  logic [7:0] out_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  crc_pad_stripper u_crc_pad_stripper (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_pad(in_pad),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_crc_err(out_crc_err)
  );

  // Stimulus stream and expected output
  logic [7:0] s_data [0:2047];
  logic       s_sop  [0:2047];
  logic       s_eop  [0:2047];
  logic       s_pad  [0:2047];
  int         s_n = 0;
  logic [7:0] e_data [0:2047];
  logic       e_sop  [0:2047];
  logic       e_eop  [0:2047];
  logic       e_err  [0:2047];
  int         e_n = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  // Build one packet of L content bytes (L even, L >= 2)
  task automatic add_packet(input int L, input int seed, input bit bad_early, input bit bad_final);
    logic [7:0]  t [0:511];
    int          tn;
    logic [15:0] crc;
    logic [7:0]  c;
    bit          pad;
    tn  = 0;
    crc = 16'hFFFF;
    for (int i = 0; i < L; i++) begin
      if (L > 80 && i == 80) begin
        t[tn] = crc[15:8] ^ (bad_early ? 8'h10 : 8'h00);
        t[tn+1] = crc[7:0];
        crc = ref_crc(crc, t[tn]);
        crc = ref_crc(crc, t[tn+1]);
        tn += 2;
      end
      c = 8'((seed * 37 + i * 13 + (i >> 3)) & 255);
      t[tn] = c;
      crc = ref_crc(crc, c);
      tn++;
      e_data[e_n] = c;
      e_sop[e_n]  = (i == 0);
      e_eop[e_n]  = (i == L - 1);
      e_err[e_n]  = (i == L - 1) && (bad_early || bad_final);
      e_n++;
    end
    t[tn]   = crc[15:8] ^ (bad_final ? 8'h01 : 8'h00);
    t[tn+1] = crc[7:0];
    tn += 2;
    pad = (tn % 4) != 0;
    if (pad) begin
      t[tn] = 8'h00;
      t[tn+1] = 8'h00;
      tn += 2;
    end
    for (int i = 0; i < tn; i++) begin
      s_data[s_n] = t[i];
      s_sop[s_n]  = (i == 0);
      s_eop[s_n]  = (i == tn - 1);
      s_pad[s_n]  = (i == tn - 1) && pad;
      s_n++;
    end
  endtask

  // Drive the stream, compare every output byte
  task automatic run(input string req, input string err_req, input int gap_pct, input int stall_pct);
    int   sp, ep, cyc, idle;
    bit   hold;
    logic [7:0] hold_data;
    sp = 0; ep = 0; cyc = 0; idle = 0; hold = 1'b0; hold_data = '0;
    while (idle < 20 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = ($urandom_range(99, 0) >= stall_pct);
      in_valid  = (sp < s_n) && ($urandom_range(99, 0) >= gap_pct);
      in_data   = (sp < s_n) ? s_data[sp] : 8'h00;
      in_sop    = (sp < s_n) ? s_sop[sp]  : 1'b0;
      in_eop    = (sp < s_n) ? s_eop[sp]  : 1'b0;
      in_pad    = (sp < s_n) ? s_pad[sp]  : 1'b0;
      #1;
      if (hold)
        check(out_valid && out_data == hold_data, "R7", "stalled byte changed",
              int'(out_data), int'(hold_data));
      hold      = out_valid && !out_ready;
      hold_data = out_data;
      if (out_valid && out_ready) begin
        if (ep >= e_n) begin
          check(1'b0, req, "extra output byte", int'(out_data), 0);
        end else begin
          check(out_data == e_data[ep] && out_sop == e_sop[ep] && out_eop == e_eop[ep],
                req, $sformatf("byte %0d {data,sop,eop}", ep),
                int'({out_data, out_sop, out_eop}), int'({e_data[ep], e_sop[ep], e_eop[ep]}));
          if (e_eop[ep])
            check(out_crc_err == e_err[ep], err_req, $sformatf("crc flag on eop byte %0d", ep),
                  int'(out_crc_err), int'(e_err[ep]));
          else if (out_crc_err)
            check(1'b0, "R10", $sformatf("crc flag on inner byte %0d", ep), 1, 0);
        end
        ep++;
      end
      if (in_valid && in_ready) sp++;
      if (sp >= s_n && ep >= e_n) idle++;
    end
    in_valid = 1'b0;
    check(ep == e_n && sp == s_n, req, "bytes delivered", ep, e_n);
    s_n = 0;
    e_n = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_short_packets();
    add_packet(2, 1, 0, 0);   // 4 bytes, no fill: R2
    add_packet(4, 2, 0, 0);   // 6 bytes + fill: R3
    add_packet(6, 3, 0, 0);
    add_packet(8, 4, 0, 0);
    add_packet(10, 5, 0, 0);
    run("R2 R3 R6", "R10", 0, 0);
  endtask

  task automatic t_length_boundary();
    add_packet(78, 6, 0, 0);  // below the early CRC point: R5
    add_packet(80, 7, 0, 0);  // exactly at it: R5
    add_packet(82, 8, 0, 0);  // first length with early CRC: R4
    add_packet(84, 9, 0, 0);
    run("R4 R5 R6", "R10", 0, 0);
  endtask

  task automatic t_backpressure();
    add_packet(200, 10, 0, 0);
    add_packet(130, 11, 0, 0);
    add_packet(12, 12, 0, 0);
    add_packet(90, 13, 0, 0);
    run("R7 R4", "R10", 30, 45);
    add_packet(100, 14, 0, 0);
    add_packet(6, 15, 0, 0);
    run("R7 R3", "R10", 0, 85);
  endtask

  task automatic t_crc_errors();
    add_packet(40, 16, 0, 1);    // final mismatch, short: R8
    add_packet(100, 17, 1, 0);   // early mismatch only: R9
    add_packet(100, 18, 0, 0);   // good long packet after error: R10
    add_packet(120, 19, 0, 1);   // final mismatch, long: R8
    add_packet(22, 20, 0, 0);
    run("R2 R4", "R8 R9 R10", 20, 30);
  endtask

  initial begin : watchdog
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_short_packets();
    t_length_boundary();
    t_backpressure();
    t_crc_errors();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule